// File: doc/BRIEF.md
# Trap Vector Dispatch Unit

When a trap is raised, this unit decides which execution level services it and builds the address of the handler. For each trap request it reads the hart's current mode bits, the current nesting depth of traps and the trap type. It then picks one of five outcomes:

- reset/error entry
- halt
- guest watchdog
- hyperprivileged handler
- privileged handler

It forms the handler PC and next PC from the matching base register. The state-saving logic downstream uses the destination code to know which registers to update.

The unit is a three-state machine:

- `S_IDLE`: waiting for a request.
- `S_ISSUE`: a dispatch result is presented for exactly one cycle.
- `S_HALT`: a sticky state entered when a trap arrives at the deepest permitted level.

Transitions:

- IDLE→ISSUE and ISSUE→ISSUE happen on an accepted request that does not halt.
- IDLE→HALT and ISSUE→HALT happen on a request at the maximum level.
- ISSUE→IDLE happens when no request is present.
- HALT is left only through reset.

Top module: `trap_dispatch`

## Requirements
- R1: The current mode is hyperprivileged when `st_hpriv` is 1, privileged when only `st_priv` is 1, and user otherwise. A user or privileged trap is handled at the privileged level, with dest code 4. A hyperprivileged trap stays hyperprivileged, with dest code 3.
- R2: When `st_red` is 1, or `cur_tl` equals MAX_TL-1, the dest code is 0. The effective type is 5 and the PC is RED_BASE OR ((5<<5) AND 0xFF), which is RED_BASE+0xA0.
- R3: A request with `cur_tl` equal to MAX_TL and `st_red` 0 produces no `disp_valid` and raises `err_halt` from the next cycle. `err_halt` stays set and further requests are ignored until reset.
- R4: A trap handled at the privileged level with `cur_tl` above MAX_PTL becomes a guest watchdog. Its dest code is 2 and its effective type is 2. Its PC is built like a hyperprivileged vector using type 2.
- R5: A trap of type HYP_TT_CUT (384) or above from a non-hyperprivileged mode goes hyperprivileged with dest code 3. Type 383 from the same state stays privileged.
- R6: The hyperprivileged PC is `htba_in` with bits 13:0 cleared, ORed with (type<<5) AND 0x3FFF.
- R7: The privileged PC is `tba_in` with bits 14:0 cleared, ORed with (type<<5) AND 0x3FFF. Bit 14 is set exactly when `cur_tl` is above 0.
- R8: `disp_npc` always equals `disp_pc` + 4.
- R9: Results appear on the cycle after the request, marked by a one-cycle `disp_valid` pulse. Requests on consecutive cycles each produce their own result.
- R10: After reset, `disp_valid` and `err_halt` are 0 and `disp_pc` is 0.
- R11: The reset/error entry takes priority over halt: `st_red` 1 with `cur_tl` = MAX_TL gives dest code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request strobe |
| trap_tt | input | TT_W | Trap type |
| st_hpriv | input | 1 | Hyperprivileged mode bit |
| st_priv | input | 1 | Privileged mode bit |
| st_red | input | 1 | Reset/error state flag |
| cur_tl | input | TL_W | Trap level before this trap |
| tba_in | input | ADDR_W | Privileged trap base |
| htba_in | input | ADDR_W | Hyperprivileged trap base |
| disp_valid | output | 1 | Result valid pulse |
| disp_dest | output | 3 | Destination code (0 reset/error, 1 halt, 2 watchdog, 3 hyper, 4 priv) |
| disp_tt | output | TT_W | Effective trap type |
| disp_pc | output | ADDR_W | Handler PC |
| disp_npc | output | ADDR_W | Handler next PC |
| err_halt | output | 1 | Sticky error halt |

## Verification
The bench targets the threshold edges of the routing:

- **Type cutoff.** Types 383 and 384 straddle it; a design that got the comparison wrong would send one of them to the wrong level.
- **Watchdog level.** Levels 2 and 3 straddle it; an off-by-one would misroute a watchdog or miss one.
- **Reset/error level.** Level MAX_TL-1 lands exactly on it.
- **Halt ordering.** The red flag combined with the maximum level checks that reset/error entry wins over halt.
- **Hyperprivileged at a deep level.** This case confirms that the watchdog applies only to traps handled at the privileged level.
- **Halt behaviour.** Requests after the halt must be ignored. A design that was not sticky would emit a vector or drop the halt.
- **Nested privileged vectors.** Level 0 against level 1 exposes a wrong bit-14 condition.
- **Back-to-back requests.** These catch a state machine that drops or stretches its pulse.

// File: rtl/tvd_pkg.sv
package tvd_pkg;

    typedef enum logic [1:0] {
        PRV_USER = 2'd0,
        PRV_PRIV = 2'd1,
        PRV_HYP  = 2'd2
    } prv_e;

    typedef enum logic [2:0] {
        DST_RED  = 3'd0,
        DST_HALT = 3'd1,
        DST_WDOG = 3'd2,
        DST_HYP  = 3'd3,
        DST_PRIV = 3'd4
    } dest_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_HALT  = 2'd2
    } fsm_e;

    localparam int TT_RED_ENTRY = 5;
    localparam int TT_WATCHDOG  = 2;
    localparam int VEC_SHIFT    = 5;
    localparam int NEST_BIT_POS = 14;
    localparam int INSN_BYTES   = 4;

endpackage

// File: rtl/tvd_classify.sv
module tvd_classify
    import tvd_pkg::*;
#(
    parameter int TT_W       = 9,
    parameter int TL_W       = 3,
    parameter int MAX_TL     = 6,
    parameter int MAX_PTL    = 2,
    parameter int HYP_TT_CUT = 384
) (
    input  logic            hpriv,
    input  logic            priv,
    input  logic            red,
    input  logic [TL_W-1:0] tl,
    input  logic [TT_W-1:0] tt,
    output dest_e           dest,
    output logic [TT_W-1:0] eff_tt
);

    localparam logic [TL_W-1:0] TL_RED  = TL_W'(MAX_TL - 1);
    localparam logic [TL_W-1:0] TL_TOP  = TL_W'(MAX_TL);
    localparam logic [TL_W-1:0] TL_PMAX = TL_W'(MAX_PTL);
    localparam logic [TT_W-1:0] TT_CUT  = TT_W'(HYP_TT_CUT);

    prv_e cur_lvl;
    prv_e nxt_lvl;

    always_comb begin
        if (hpriv)     cur_lvl = PRV_HYP;
        else if (priv) cur_lvl = PRV_PRIV;
        else           cur_lvl = PRV_USER;
    end

    always_comb begin
        unique case (cur_lvl)
            PRV_HYP: nxt_lvl = PRV_HYP;
            default: nxt_lvl = PRV_PRIV;
        endcase
    end

    always_comb begin
        eff_tt = tt;
        if (red || tl == TL_RED) begin
            dest   = DST_RED;
            eff_tt = TT_W'(TT_RED_ENTRY);
        end else if (tl == TL_TOP) begin
            dest   = DST_HALT;
        end else if (nxt_lvl == PRV_PRIV && tl > TL_PMAX) begin
            dest   = DST_WDOG;
            eff_tt = TT_W'(TT_WATCHDOG);
        end else if (nxt_lvl == PRV_HYP || tt >= TT_CUT) begin
            dest   = DST_HYP;
        end else begin
            dest   = DST_PRIV;
        end
    end

endmodule

// File: rtl/tvd_vector.sv
module tvd_vector
    import tvd_pkg::*;
#(
    parameter int              ADDR_W   = 48,
    parameter int              TT_W     = 9,
    parameter int              TL_W     = 3,
    parameter logic [ADDR_W-1:0] RED_BASE = 48'hFF_F000_0000
) (
    input  dest_e             dest,
    input  logic [TT_W-1:0]   eff_tt,
    input  logic [TL_W-1:0]   tl,
    input  logic [ADDR_W-1:0] tba,
    input  logic [ADDR_W-1:0] htba,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] npc
);

    localparam logic [ADDR_W-1:0] LOW14    = ADDR_W'(14'h3FFF);
    localparam logic [ADDR_W-1:0] LOW15    = ADDR_W'(15'h7FFF);
    localparam logic [ADDR_W-1:0] RED_LOW  = ADDR_W'(8'hFF);
    localparam logic [ADDR_W-1:0] NEST_BIT = ADDR_W'(1) << NEST_BIT_POS;

    logic [ADDR_W-1:0] tt_sh;
    logic [ADDR_W-1:0] hyp_pc;
    logic [ADDR_W-1:0] prv_pc;
    logic [ADDR_W-1:0] red_pc;

    assign tt_sh  = ADDR_W'(eff_tt) << VEC_SHIFT;
    assign red_pc = RED_BASE | (tt_sh & RED_LOW);
    assign hyp_pc = (htba & ~LOW14) | (tt_sh & LOW14);
    assign prv_pc = (tba & ~LOW15) | ((tl != '0) ? NEST_BIT : '0) | (tt_sh & LOW14);

    always_comb begin
        unique case (dest)
            DST_RED:           pc = red_pc;
            DST_WDOG, DST_HYP: pc = hyp_pc;
            DST_PRIV:          pc = prv_pc;
            default:           pc = '0;
        endcase
    end

    assign npc = pc + ADDR_W'(INSN_BYTES);

endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
    import tvd_pkg::*;
#(
    parameter int                ADDR_W     = 48,
    parameter int                TT_W       = 9,
    parameter int                MAX_TL     = 6,
    parameter int                MAX_PTL    = 2,
    parameter int                HYP_TT_CUT = 384,
    parameter int                TL_W       = $clog2(MAX_TL + 1),
    parameter logic [ADDR_W-1:0] RED_BASE   = 48'hFF_F000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic [TT_W-1:0]   trap_tt,
    input  logic              st_hpriv,
    input  logic              st_priv,
    input  logic              st_red,
    input  logic [TL_W-1:0]   cur_tl,
    input  logic [ADDR_W-1:0] tba_in,
    input  logic [ADDR_W-1:0] htba_in,
    output logic              disp_valid,
    output logic [2:0]        disp_dest,
    output logic [TT_W-1:0]   disp_tt,
    output logic [ADDR_W-1:0] disp_pc,
    output logic [ADDR_W-1:0] disp_npc,
    output logic              err_halt
);

    dest_e             cls_dest;
    logic [TT_W-1:0]   cls_tt;
    logic [ADDR_W-1:0] vec_pc;
    logic [ADDR_W-1:0] vec_npc;
    fsm_e              state_q;
    fsm_e              state_d;
    logic              accept;
    logic              load;

    tvd_classify #(
        .TT_W(TT_W), .TL_W(TL_W), .MAX_TL(MAX_TL),
        .MAX_PTL(MAX_PTL), .HYP_TT_CUT(HYP_TT_CUT)
    ) u_cls (
        .hpriv(st_hpriv), .priv(st_priv), .red(st_red),
        .tl(cur_tl), .tt(trap_tt), .dest(cls_dest), .eff_tt(cls_tt)
    );

    tvd_vector #(
        .ADDR_W(ADDR_W), .TT_W(TT_W), .TL_W(TL_W), .RED_BASE(RED_BASE)
    ) u_vec (
        .dest(cls_dest), .eff_tt(cls_tt), .tl(cur_tl),
        .tba(tba_in), .htba(htba_in), .pc(vec_pc), .npc(vec_npc)
    );

    assign accept = trap_req && (state_q != S_HALT);
    assign load   = accept && (cls_dest != DST_HALT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_ISSUE: begin
                if (!trap_req)                  state_d = S_IDLE;
                else if (cls_dest == DST_HALT)  state_d = S_HALT;
                else                            state_d = S_ISSUE;
            end
            S_HALT:  state_d = S_HALT;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_dest <= '0;
            disp_tt   <= '0;
            disp_pc   <= '0;
            disp_npc  <= '0;
        end else if (load) begin
            disp_dest <= cls_dest;
            disp_tt   <= cls_tt;
            disp_pc   <= vec_pc;
            disp_npc  <= vec_npc;
        end
    end

    assign disp_valid = (state_q == S_ISSUE);
    assign err_halt   = (state_q == S_HALT);

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> $past(trap_req));

    // R3
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_halt |=> err_halt);

    // R3
    halt_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_halt |=> !disp_valid);

    // R2
    red_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_dest == 3'(DST_RED)) |-> disp_tt == TT_W'(TT_RED_ENTRY));

    // R4
    wdog_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_dest == 3'(DST_WDOG)) |-> disp_tt == TT_W'(TT_WATCHDOG));

    // R8
    npc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> disp_npc == disp_pc + ADDR_W'(INSN_BYTES));

    // R11
    red_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && $past(st_red)) |-> disp_dest == 3'(DST_RED));

endmodule

// File: tb/sim_trap_dispatch.sv
module sim_trap_dispatch;

    localparam int ADDR_W = 48;
    localparam int TT_W   = 9;
    localparam int TL_W   = 3;
    localparam logic [ADDR_W-1:0] RBASE = 48'hFF_F000_0000;
    localparam logic [ADDR_W-1:0] TBA   = 48'h1234_5678_9ABC;
    localparam logic [ADDR_W-1:0] HTBA  = 48'hABCD_0000_7FFF;

    typedef struct packed {
        logic       hp;
        logic       pv;
        logic       rd;
        logic [2:0] tl;
        logic [8:0] tt;
        logic [2:0] dest;
        logic [8:0] ett;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b0,3'd0,9'h024,3'd4,9'h024},  // R1 R7 user, level 0
        '{1'b0,1'b1,1'b0,3'd1,9'h080,3'd4,9'h080},  // R1 R7 priv, nested
        '{1'b1,1'b1,1'b0,3'd0,9'h010,3'd3,9'h010},  // R1 R6 hyper stays hyper
        '{1'b0,1'b0,1'b0,3'd1,9'h180,3'd3,9'h180},  // R5 at cutoff
        '{1'b0,1'b0,1'b0,3'd1,9'h17F,3'd4,9'h17F},  // R5 just below cutoff
        '{1'b0,1'b1,1'b0,3'd3,9'h030,3'd2,9'h002},  // R4 watchdog
        '{1'b0,1'b1,1'b0,3'd2,9'h030,3'd4,9'h030},  // R4 boundary no watchdog
        '{1'b1,1'b0,1'b0,3'd3,9'h030,3'd3,9'h030},  // R4 hyper at depth
        '{1'b0,1'b0,1'b0,3'd5,9'h034,3'd0,9'h005},  // R2 level MAX-1
        '{1'b1,1'b0,1'b1,3'd1,9'h062,3'd0,9'h005},  // R2 red flag
        '{1'b0,1'b0,1'b0,3'd4,9'h1FF,3'd2,9'h002},  // R4 watchdog beats cutoff
        '{1'b0,1'b0,1'b0,3'd0,9'h1FF,3'd3,9'h1FF}   // R5 top type
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trap_req = 1'b0;
    logic [TT_W-1:0]   trap_tt = '0;
    logic              st_hpriv = 1'b0, st_priv = 1'b0, st_red = 1'b0;
    logic [TL_W-1:0]   cur_tl = '0;
    logic [ADDR_W-1:0] tba_in = TBA, htba_in = HTBA;
    logic              disp_valid, err_halt;
    logic [2:0]        disp_dest;
    logic [TT_W-1:0]   disp_tt;
    logic [ADDR_W-1:0] disp_pc, disp_npc;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    trap_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_tt(trap_tt),
        .st_hpriv(st_hpriv), .st_priv(st_priv), .st_red(st_red),
        .cur_tl(cur_tl), .tba_in(tba_in), .htba_in(htba_in),
        .disp_valid(disp_valid), .disp_dest(disp_dest), .disp_tt(disp_tt),
        .disp_pc(disp_pc), .disp_npc(disp_npc), .err_halt(err_halt)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] exp_pc(input logic [2:0] d,
            input logic [8:0] t, input logic [2:0] l);
        logic [ADDR_W-1:0] s;
        s = ADDR_W'(t) << 5;
        case (d)
            3'd0:       return RBASE | (s & 48'hFF);
            3'd2, 3'd3: return (HTBA & ~48'h3FFF) | (s & 48'h3FFF);
            3'd4:       return (TBA & ~48'h7FFF) | ((l != 0) ? 48'h4000 : 48'h0)
                               | (s & 48'h3FFF);
            default:    return '0;
        endcase
    endfunction

    task automatic drive(input vec_t v);
        st_hpriv = v.hp; st_priv = v.pv; st_red = v.rd;
        cur_tl = v.tl; trap_tt = v.tt; trap_req = 1'b1;
    endtask

    task automatic verify(input vec_t v, input string tag);
        logic [ADDR_W-1:0] ep;
        ep = exp_pc(v.dest, v.ett, v.tl);
        check(disp_valid == 1'b1, {tag, " R9 valid"}, 64'(disp_valid), 64'd1);
        check(disp_dest == v.dest, {tag, " dest"}, 64'(disp_dest), 64'(v.dest));
        check(disp_tt == v.ett, {tag, " tt"}, 64'(disp_tt), 64'(v.ett));
        check(disp_pc == ep, {tag, " R6/R7 pc"}, 64'(disp_pc), 64'(ep));
        check(disp_npc == ep + 4, {tag, " R8 npc"}, 64'(disp_npc), 64'(ep + 4));
    endtask

    task automatic apply(input vec_t v, input string tag);
        @(negedge clk);
        drive(v);
        @(negedge clk);
        trap_req = 1'b0;
        verify(v, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        trap_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        vec_t v;
        do_reset();
        @(negedge clk);
        // R10 reset state
        check(disp_valid == 1'b0, "R10 valid", 64'(disp_valid), 64'd0);
        check(err_halt == 1'b0, "R10 halt", 64'(err_halt), 64'd0);
        check(disp_pc == '0, "R10 pc", 64'(disp_pc), 64'd0);

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i], $sformatf("vec%0d", i));
        end

        // R9 back-to-back requests, single pulse afterwards
        @(negedge clk);
        drive(TBL[0]);
        @(negedge clk);
        verify(TBL[0], "b2b0");
        drive(TBL[3]);
        @(negedge clk);
        trap_req = 1'b0;
        verify(TBL[3], "b2b1");
        @(negedge clk);
        check(disp_valid == 1'b0, "R9 pulse ends", 64'(disp_valid), 64'd0);

        // R11 red flag at maximum level enters reset/error state
        v = '{1'b0,1'b1,1'b1,3'd6,9'h030,3'd0,9'h005};
        apply(v, "R11 red over halt");
        check(err_halt == 1'b0, "R11 no halt", 64'(err_halt), 64'd0);

        // R3 maximum level halts
        v = '{1'b0,1'b1,1'b0,3'd6,9'h030,3'd1,9'h030};
        @(negedge clk);
        drive(v);
        @(negedge clk);
        trap_req = 1'b0;
        check(disp_valid == 1'b0, "R3 no valid", 64'(disp_valid), 64'd0);
        check(err_halt == 1'b1, "R3 halt set", 64'(err_halt), 64'd1);
        // R3 later request ignored
        @(negedge clk);
        drive(TBL[0]);
        @(negedge clk);
        trap_req = 1'b0;
        check(disp_valid == 1'b0, "R3 ignored", 64'(disp_valid), 64'd0);
        check(err_halt == 1'b1, "R3 sticky", 64'(err_halt), 64'd1);

        // R10 reset clears halt, normal operation resumes
        do_reset();
        @(negedge clk);
        check(err_halt == 1'b0, "R10 halt cleared", 64'(err_halt), 64'd0);
        apply(TBL[1], "R1 after reset");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule